// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit operands by processing one multiplier bit per pair of clock cycles. A shared W-bit input bus feeds two operand registers. A multiplicand strobe captures the bus into the multiplicand register, and a multiplier strobe captures it into the low half of the product register. A start pulse then launches the multiplication. The 2W-bit result is always visible on the product output as the accumulator concatenated with the multiplier/product register.

A hardwired three-state controller runs the datapath. It has an idle state, an add state and a shift state, encoded 00, 01 and 10. In the add state, the multiplicand is added into the accumulator when the current low bit of the multiplier is 1, and the adder's carry goes into a carry flop. In the shift state, the carry:accumulator:multiplier chain moves one place to the right with a zero shifted into the carry, and an iteration counter counts down. The controller tests that counter for zero before it decrements, and this test decides whether to return to idle or to run another add/shift pair.

Top module: `shift_add_mult`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it is released, busy and done are 0 and the product is all zeros.
- R2: While idle, the multiplicand strobe loads din into the multiplicand register. The multiplier strobe loads din into the multiplier register, which forms product bits [W-1:0], and the upper W product bits are left unchanged.
- R3: A start pulse sampled while idle makes busy 1 from the next cycle onward, and busy stays 1 for exactly 2W cycles.
- R4: When busy falls, the product equals the unsigned product of the loaded multiplicand and multiplier, including results where the add carries out (for example 1010 x 1011 = 01101110 and 1111 x 1111 = 11100001 for W = 4).
- R5: done is a single-cycle pulse in the first idle cycle after a multiplication. In that cycle the final product is valid.
- R6: Both load strobes are ignored while busy, so the result uses the operands that were present at the start.
- R7: A start pulse while busy has no effect on the sequence or the result.
- R8: While idle with no strobe, the product output holds its value.
- R9: The add state is always followed by the shift state. After a shift the carry flop is 0. The state code 11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, sampled while idle |
| ld_mcand | input | 1 | Load din into the multiplicand register (idle only) |
| ld_mplier | input | 1 | Load din into the multiplier register (idle only) |
| din | input | W | Shared operand bus |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2W | Accumulator concatenated with the multiplier/product register |

## Verification
The assertions assume that the load strobes and the start pulse are free of X and that reset is held for at least one clock edge. Apart from that they accept any input pattern, including strobes and start pulses that arrive while busy. The stimulus changes the inputs only on falling edges, holds reset high for several edges, and drives the strobes and start pulse during busy on purpose to exercise R6 and R7. The product is compared only while the block is idle, because the intermediate accumulator contents are not part of the contract.

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           ld_mcand,
  input  logic           ld_mplier,
  input  logic [W-1:0]   din,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int PW = (W > 2) ? $clog2(W) : 1;
  localparam logic [PW-1:0] P_INIT = PW'(W - 1);

  typedef enum logic [1:0] {S_IDLE = 2'b00, S_ADD = 2'b01, S_SHIFT = 2'b10} st_t;

  st_t           st;
  logic [W-1:0]  b, a, q;
  logic          c;
  logic [PW-1:0] p;

  wire in_idle  = (st == S_IDLE);
  wire in_add   = (st == S_ADD);
  wire in_shift = (st == S_SHIFT);
  wire z        = (p == '0);
  wire start    = in_idle & go;
  wire do_load  = in_add & q[0];
  wire clr_c    = start | in_shift;

  wire [W:0] sum = {1'b0, a} + {1'b0, b};

  wire m1 = in_add;
  wire m0 = start | (in_shift & ~z);
  st_t st_nxt;
  assign st_nxt = st_t'({m1, m0});

  assign busy    = ~in_idle;
  assign product = {a, q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      b    <= '0;
      a    <= '0;
      q    <= '0;
      c    <= 1'b0;
      p    <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_nxt;
      done <= in_shift & z;
      if (in_idle && ld_mcand) b <= din;
      if (in_idle && ld_mplier) q <= din;
      if (start) begin
        a <= '0;
        p <= P_INIT;
      end
      if (do_load) a <= sum[W-1:0];
      if (clr_c) c <= 1'b0;
      else if (do_load) c <= sum[W];
      if (in_shift) begin
        a <= {c, a[W-1:1]};
        q <= {a[0], q[W-1:1]};
        p <= p - PW'(1);
      end
    end
  end

  assert_legal_state_R9: assert property (@(posedge clk) disable iff (rst)
    st != 2'b11);

  assert_add_then_shift_R9: assert property (@(posedge clk) disable iff (rst)
    in_add |=> in_shift);

  assert_shift_zero_fill_R9: assert property (@(posedge clk) disable iff (rst)
    in_shift |=> (c == 1'b0));

  assert_start_init_R3: assert property (@(posedge clk) disable iff (rst)
    (in_idle && go) |=> (busy && a == '0 && p == P_INIT && !done));

  assert_mcand_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(b));

  assert_done_on_finish_R5: assert property (@(posedge clk) disable iff (rst)
    (in_shift && p == '0) |=> (done && !busy));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !go && !ld_mplier) |=> $stable(product));
endmodule

// File: tb/test_shift_add_mult.sv
`timescale 1ns/100ps
module test_shift_add_mult;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           go = 1'b0, ld_mcand = 1'b0, ld_mplier = 1'b0;
  logic [W-1:0]   din = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int checks = 0;
  int failures = 0;

  shift_add_mult #(.W(W)) i_shift_add_mult (
    .clk(clk), .rst(rst), .go(go), .ld_mcand(ld_mcand), .ld_mplier(ld_mplier),
    .din(din), .busy(busy), .done(done), .product(product)
  );

  always #2.5 clk = ~clk;

  // behavioural reference, advanced on every rising edge
  logic [W-1:0]   m_b = '0, m_q = '0;
  logic [2*W-1:0] m_prod = '0;
  int             m_cnt = 0;
  logic           m_done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_b = '0; m_q = '0; m_prod = '0; m_cnt = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_cnt == 0) begin
        if (ld_mcand) m_b = din;
        if (ld_mplier) begin
          m_q = din;
          m_prod[W-1:0] = din;
        end
        if (go) m_cnt = 2 * W;
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1'b1;
          m_prod = {{W{1'b0}}, m_b} * {{W{1'b0}}, m_q};
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == (m_cnt != 0), "R3/R9 busy", 32'(busy), 32'(m_cnt != 0));
      chk(done == m_done, "R5 done", 32'(done), 32'(m_done));
      if (!busy) chk(product == m_prod, "R2/R8 idle product", 32'(product), 32'(m_prod));
    end
  end

  task automatic run_mult(input logic [W-1:0] x, input logic [W-1:0] y, input bit noisy);
    logic [2*W-1:0] exp;
    exp = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    @(negedge clk); din = x; ld_mcand = 1'b1;
    @(negedge clk); ld_mcand = 1'b0; din = y; ld_mplier = 1'b1;
    @(negedge clk); ld_mplier = 1'b0; go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int k = 0; k < 2 * W; k++) begin
      if (noisy && k >= 1 && k < 2 * W - 1) begin
        din = ~x; ld_mcand = k[0]; ld_mplier = ~k[0]; go = 1'b1;  // R6, R7
      end else begin
        ld_mcand = 1'b0; ld_mplier = 1'b0; go = 1'b0;
      end
      @(negedge clk);
    end
    ld_mcand = 1'b0; ld_mplier = 1'b0; go = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R3/R5 finish", {30'd0, busy, done}, 32'd1);
    chk(product == exp, noisy ? "R6/R7 product" : "R4 product", 32'(product), 32'(exp));
    @(negedge clk);
    chk(done === 1'b0, "R5 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 in reset",
        {23'd0, busy, product}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 after reset",
        {23'd0, busy, product}, 32'd0);

    run_mult(4'b0101, 4'b0011, 1'b0);
    run_mult(4'b1010, 4'b1011, 1'b0);
    chk(product == 8'b01101110, "R4 1010x1011", 32'(product), 32'h6e);
    run_mult(4'hF, 4'hF, 1'b0);
    chk(product == 8'hE1, "R4 1111x1111", 32'(product), 32'he1);

    // R8 hold, then R2 multiplier load keeps the upper half
    repeat (5) @(negedge clk);
    chk(product == 8'hE1, "R8 held", 32'(product), 32'he1);
    din = 4'h6; ld_mplier = 1'b1;
    @(negedge clk); ld_mplier = 1'b0;
    chk(product == 8'hE6, "R2 low half load", 32'(product), 32'he6);

    run_mult(4'h9, 4'hC, 1'b1);
    run_mult(4'h7, 4'h0, 1'b1);

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run_mult(x[W-1:0], y[W-1:0], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule